// File: doc/BRIEF.md
# Configurable Dual-Output Logic Cell Output Stage

This block is the output stage of one programmable logic cell. It chooses a one-bit data term from a shared sum term, a private bypass term or a direct pad input. It can invert the logic term, then keep the result in one storage bit that acts either as an edge-loaded flop or as a level-following latch. Next to the stored value, the cell drives a second output that is purely combinational: the bypass term with its own polarity option. That output does not depend on what is stored.

The storage control signals each come from a global source or from a product-term source, chosen by configuration bits. These are the load clock, the load enable, the clear and the preset. The load clock is one of several global clocks or a product-term clock. The cell runs from one system clock, `clk`, and treats every selected control as a level that it samples on that clock. A "rising edge" of the selected load clock means a cycle in which the selected level is high after it was low in the previous cycle. The clock enable only qualifies loading and never gates any clock.

Top module: `mcell_out`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge of `clk`, `q_out` becomes 0 after that edge, and the remembered level of the selected load clock is cleared to low.
- R2: With `cfg_use_pad`=0, `cfg_use_bypass`=1 picks `bypass_term` as the logic term and `cfg_use_bypass`=0 picks `sum_term`.
- R3: With `cfg_use_pad`=0, `cfg_d_inv`=1 stores the inverse of the logic term and `cfg_d_inv`=0 stores it unchanged.
- R4: With `cfg_use_pad`=1, the storage data is `pad_in` taken as is, whatever `cfg_d_inv`, `cfg_use_bypass` and the two terms are.
- R5: Flop mode (`cfg_latch`=0): the bit loads only in a `clk` cycle where the selected load clock is sampled high and was sampled low in the previous cycle, and `q_out` shows the new value after that `clk` edge.
- R6: Latch mode (`cfg_latch`=1): the bit loads the data in every `clk` cycle in which the selected load clock is sampled high, and holds while it is low.
- R7: The enable is `pt_ce` when `cfg_ce_pt`=1 and `g_ce` otherwise. While the enable is low, no load happens in either mode and `q_out` holds.
- R8: The load clock is `pt_clk` when `cfg_clk_pt`=1, and otherwise `gclk[cfg_gclk_sel]`, where bit index i is global clock i.
- R9: The clear is `pt_rst` when `cfg_rst_pt`=1 and `g_rst` otherwise, and the preset is `pt_set` when `cfg_set_pt`=1 and `g_set` otherwise. A sampled clear forces the bit to 0 and a sampled preset forces it to 1. Clear beats preset, and both beat any load.
- R10: `comb_out` equals `bypass_term` XOR `cfg_comb_inv` in the same cycle, whatever the stored bit and the storage data path are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sum_term | input | 1 | Term from the sharing array |
| bypass_term | input | 1 | Private bypass product term |
| pad_in | input | 1 | Direct input from the I/O cell |
| gclk | input | NUM_GCLK | Global load clocks, sampled as levels |
| pt_clk | input | 1 | Product-term load clock |
| g_ce | input | 1 | Global load enable |
| pt_ce | input | 1 | Product-term load enable |
| g_rst | input | 1 | Global clear |
| pt_rst | input | 1 | Product-term clear |
| g_set | input | 1 | Global preset |
| pt_set | input | 1 | Product-term preset |
| cfg_use_bypass | input | 1 | Logic term: 1 bypass, 0 sum |
| cfg_d_inv | input | 1 | Invert the logic term before storage |
| cfg_use_pad | input | 1 | Store `pad_in` instead of the logic term |
| cfg_latch | input | 1 | 1 latch mode, 0 flop mode |
| cfg_gclk_sel | input | SEL_W | Index of the global load clock |
| cfg_clk_pt | input | 1 | Use `pt_clk` as the load clock |
| cfg_ce_pt | input | 1 | Use `pt_ce` as the enable |
| cfg_rst_pt | input | 1 | Use `pt_rst` as the clear |
| cfg_set_pt | input | 1 | Use `pt_set` as the preset |
| cfg_comb_inv | input | 1 | Invert the combinational output |
| q_out | output | 1 | Stored bit |
| comb_out | output | 1 | Combinational output |

## Verification
The assertions assume that every control and configuration input is stable around each rising edge of `clk`. They also assume that `cfg_gclk_sel` stays below `NUM_GCLK`, so the selected clock level is never undefined. The stimulus changes all inputs only on the falling edge of `clk` and draws `cfg_gclk_sel` from the valid range. It toggles the chosen load clock slowly enough that both held and loading cycles occur in each configuration. Clear and preset pulses are rare, and some of them overlap, so that both the priority between them and plain load behaviour are exercised.

// File: rtl/mc_pkg.sv
// Package: shared types for the logic-cell output stage.
// Assumes: single-bit data path; all controls are levels sampled on clk.
package mc_pkg;

    typedef enum logic {
        STORE_FLOP  = 1'b0,
        STORE_LATCH = 1'b1
    } store_mode_e;

    typedef struct packed {
        logic lvl;   // selected load clock level this cycle
        logic rise;  // selected load clock high now, low last cycle
        logic en;    // selected load enable
        logic clr;   // selected clear
        logic pre;   // selected preset
    } ctrl_t;

endpackage

// File: rtl/mc_term_path.sv
// Module: mc_term_path
// Builds the storage data term (sum or bypass, optional inversion, or the
// raw pad input) and the independent combinational output.
// Assumes: purely combinational, no state.
module mc_term_path (
    input  logic sum_term,
    input  logic bypass_term,
    input  logic pad_in,
    input  logic cfg_use_bypass,
    input  logic cfg_d_inv,
    input  logic cfg_use_pad,
    input  logic cfg_comb_inv,
    output logic d_o,
    output logic comb_o
);

    logic logic_term;

    // Choose the logic term, apply polarity, then the pad override.
    always_comb begin
        logic_term = cfg_use_bypass ? bypass_term : sum_term;
        d_o        = cfg_use_pad ? pad_in : (logic_term ^ cfg_d_inv);
    end

    // Second output: bypass term with its own polarity, no storage involved.
    always_comb begin
        comb_o = bypass_term ^ cfg_comb_inv;
    end

endmodule

// File: rtl/mc_ctrl_sel.sv
// Module: mc_ctrl_sel
// Picks the load clock, enable, clear and preset from global or
// product-term sources, and detects a rising level of the chosen clock.
// Assumes: cfg_gclk_sel < NUM_GCLK; controls are stable around clk edges.
module mc_ctrl_sel #(
    parameter int NUM_GCLK = 4,
    parameter int SEL_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic                g_ce,
    input  logic                pt_ce,
    input  logic                g_rst,
    input  logic                pt_rst,
    input  logic                g_set,
    input  logic                pt_set,
    input  logic [SEL_W-1:0]    cfg_gclk_sel,
    input  logic                cfg_clk_pt,
    input  logic                cfg_ce_pt,
    input  logic                cfg_rst_pt,
    input  logic                cfg_set_pt,
    output mc_pkg::ctrl_t       ctrl_o
);

    logic [NUM_GCLK-1:0] pick;
    logic                glob_lvl;
    logic                sel_lvl;
    logic                prev_lvl;

    // One AND term per global clock; the OR of them is the chosen level.
    for (genvar g = 0; g < NUM_GCLK; g++) begin : g_pick
        assign pick[g] = gclk[g] & (cfg_gclk_sel == SEL_W'(g));
    end
    assign glob_lvl = |pick;

    // Source selection for all four controls.
    always_comb begin
        sel_lvl     = cfg_clk_pt ? pt_clk : glob_lvl;
        ctrl_o.lvl  = sel_lvl;
        ctrl_o.rise = sel_lvl & ~prev_lvl;
        ctrl_o.en   = cfg_ce_pt  ? pt_ce  : g_ce;
        ctrl_o.clr  = cfg_rst_pt ? pt_rst : g_rst;
        ctrl_o.pre  = cfg_set_pt ? pt_set : g_set;
    end

    // Remember last cycle's chosen clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= sel_lvl;
    end

    // A high chosen level can never be followed directly by a rise.
    assert_no_double_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o.lvl |=> !ctrl_o.rise);

    // Product-term clock selected and low means no rise this cycle.
    assert_pt_clock_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk_pt && !pt_clk) |-> !ctrl_o.rise);

endmodule

// File: rtl/mc_store.sv
// Module: mc_store
// One storage bit acting as an edge-loaded flop or a level-following
// latch, with clear and preset that win over any load.
// Assumes: ctrl_i comes from mc_ctrl_sel in the same clk domain.
module mc_store (
    input  logic                clk,
    input  logic                rst_n,
    input  mc_pkg::store_mode_e mode_i,
    input  logic                d_i,
    input  mc_pkg::ctrl_t       ctrl_i,
    output logic                q_o
);

    logic load;

    // Load condition depends on the storage mode.
    always_comb begin
        if (mode_i == mc_pkg::STORE_LATCH) load = ctrl_i.lvl  & ctrl_i.en;
        else                               load = ctrl_i.rise & ctrl_i.en;
    end

    // State update: reset, clear, preset, load, hold in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n)          q_o <= 1'b0;
        else if (ctrl_i.clr) q_o <= 1'b0;
        else if (ctrl_i.pre) q_o <= 1'b1;
        else if (load)       q_o <= d_i;
    end

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i.clr |=> !q_o);

    assert_preset_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.pre && !ctrl_i.clr) |=> q_o);

    assert_enable_low_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i.en && !ctrl_i.clr && !ctrl_i.pre) |=> $stable(q_o));

    assert_flop_loads_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == mc_pkg::STORE_FLOP && ctrl_i.rise && ctrl_i.en
         && !ctrl_i.clr && !ctrl_i.pre) |=> (q_o == $past(d_i)));

    assert_latch_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == mc_pkg::STORE_LATCH && ctrl_i.lvl && ctrl_i.en
         && !ctrl_i.clr && !ctrl_i.pre) |=> (q_o == $past(d_i)));

endmodule

// File: rtl/mcell_out.sv
// Module: mcell_out (top)
// Output stage of one programmable logic cell: data term selection,
// control source selection and one storage bit, plus a free
// combinational output.
// Assumes: single clk domain; global and product-term clocks are levels.
module mcell_out #(
    parameter  int NUM_GCLK = 4,
    localparam int SEL_W    = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sum_term,
    input  logic                bypass_term,
    input  logic                pad_in,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic                g_ce,
    input  logic                pt_ce,
    input  logic                g_rst,
    input  logic                pt_rst,
    input  logic                g_set,
    input  logic                pt_set,
    input  logic                cfg_use_bypass,
    input  logic                cfg_d_inv,
    input  logic                cfg_use_pad,
    input  logic                cfg_latch,
    input  logic [SEL_W-1:0]    cfg_gclk_sel,
    input  logic                cfg_clk_pt,
    input  logic                cfg_ce_pt,
    input  logic                cfg_rst_pt,
    input  logic                cfg_set_pt,
    input  logic                cfg_comb_inv,
    output logic                q_out,
    output logic                comb_out
);

    logic                d_sel;
    mc_pkg::ctrl_t       ctrl;
    mc_pkg::store_mode_e mode;

    assign mode = mc_pkg::store_mode_e'(cfg_latch);

    mc_term_path u_term (
        .sum_term       (sum_term),
        .bypass_term    (bypass_term),
        .pad_in         (pad_in),
        .cfg_use_bypass (cfg_use_bypass),
        .cfg_d_inv      (cfg_d_inv),
        .cfg_use_pad    (cfg_use_pad),
        .cfg_comb_inv   (cfg_comb_inv),
        .d_o            (d_sel),
        .comb_o         (comb_out)
    );

    mc_ctrl_sel #(
        .NUM_GCLK (NUM_GCLK),
        .SEL_W    (SEL_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .gclk         (gclk),
        .pt_clk       (pt_clk),
        .g_ce         (g_ce),
        .pt_ce        (pt_ce),
        .g_rst        (g_rst),
        .pt_rst       (pt_rst),
        .g_set        (g_set),
        .pt_set       (pt_set),
        .cfg_gclk_sel (cfg_gclk_sel),
        .cfg_clk_pt   (cfg_clk_pt),
        .cfg_ce_pt    (cfg_ce_pt),
        .cfg_rst_pt   (cfg_rst_pt),
        .cfg_set_pt   (cfg_set_pt),
        .ctrl_o       (ctrl)
    );

    mc_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode),
        .d_i    (d_sel),
        .ctrl_i (ctrl),
        .q_o    (q_out)
    );

    // Stable bypass term and polarity keep the combinational output stable.
    assert_comb_indep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(bypass_term) && $stable(cfg_comb_inv)) |-> $stable(comb_out));

    // Pad selected in flop mode: a load stores the pad value.
    assert_pad_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_use_pad && ctrl.rise && ctrl.en && !ctrl.clr && !ctrl.pre && !cfg_latch)
        |=> (q_out == $past(pad_in)));

endmodule

// File: tb/mcell_out_bench.sv
module mcell_out_bench;

    localparam int NG = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic sum_term, bypass_term, pad_in;
    logic [NG-1:0] gclk;
    logic pt_clk, g_ce, pt_ce, g_rst, pt_rst, g_set, pt_set;
    logic cfg_use_bypass, cfg_d_inv, cfg_use_pad, cfg_latch;
    logic [1:0] cfg_gclk_sel;
    logic cfg_clk_pt, cfg_ce_pt, cfg_rst_pt, cfg_set_pt, cfg_comb_inv;
    logic q_out, comb_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    // reference state
    int    exp_q = 0;
    int    exp_prev = 0;
    string exp_tag = "R1";

    always #10 clk = ~clk;   // 50 MHz

    mcell_out #(.NUM_GCLK(NG)) u_mcell_out (
        .clk(clk), .rst_n(rst_n), .sum_term(sum_term), .bypass_term(bypass_term),
        .pad_in(pad_in), .gclk(gclk), .pt_clk(pt_clk), .g_ce(g_ce), .pt_ce(pt_ce),
        .g_rst(g_rst), .pt_rst(pt_rst), .g_set(g_set), .pt_set(pt_set),
        .cfg_use_bypass(cfg_use_bypass), .cfg_d_inv(cfg_d_inv), .cfg_use_pad(cfg_use_pad),
        .cfg_latch(cfg_latch), .cfg_gclk_sel(cfg_gclk_sel), .cfg_clk_pt(cfg_clk_pt),
        .cfg_ce_pt(cfg_ce_pt), .cfg_rst_pt(cfg_rst_pt), .cfg_set_pt(cfg_set_pt),
        .cfg_comb_inv(cfg_comb_inv), .q_out(q_out), .comb_out(comb_out)
    );

    // Behavioural reference, evaluated on each rising clk edge.
    always @(posedge clk) begin
        int lvl, en, clr, pre, d, rise, term;
        lvl  = cfg_clk_pt ? int'(pt_clk) : int'(gclk[cfg_gclk_sel]);
        en   = cfg_ce_pt  ? int'(pt_ce)  : int'(g_ce);
        clr  = cfg_rst_pt ? int'(pt_rst) : int'(g_rst);
        pre  = cfg_set_pt ? int'(pt_set) : int'(g_set);
        term = cfg_use_bypass ? int'(bypass_term) : int'(sum_term);
        d    = cfg_use_pad ? int'(pad_in) : (cfg_d_inv ? 1 - term : term);
        rise = (lvl == 1 && exp_prev == 0) ? 1 : 0;
        if (!rst_n) begin
            exp_q = 0; exp_prev = 0; exp_tag = "R1";
        end else begin
            exp_prev = lvl;
            if (clr == 1) begin
                exp_q = 0; exp_tag = (pre == 1) ? "R9 clear-over-preset" : "R9 clear";
            end else if (pre == 1) begin
                exp_q = 1; exp_tag = "R9 preset";
            end else if (en == 0) begin
                exp_tag = "R7 enable low";
            end else if (cfg_latch) begin
                if (lvl == 1) begin
                    exp_q = d;
                    exp_tag = cfg_use_pad ? "R6 R8 R4 load" : "R6 R8 R2 R3 load";
                end else exp_tag = "R6 hold";
            end else begin
                if (rise == 1) begin
                    exp_q = d;
                    exp_tag = cfg_use_pad ? "R5 R8 R4 load" : "R5 R8 R2 R3 load";
                end else exp_tag = "R5 hold";
            end
        end
    end

    task automatic check_bit(input string tag, input logic act, input int exp);
        checks++;
        if (act !== logic'(exp[0])) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Randomise one cycle's inputs; probabilities in percent.
    task automatic drive(input int clk_tog, input int ctl_rate);
        sum_term    = 1'($urandom_range(0, 1));
        bypass_term = 1'($urandom_range(0, 1));
        pad_in      = 1'($urandom_range(0, 1));
        for (int g = 0; g < NG; g++)
            if ($urandom_range(0, 99) < clk_tog) gclk[g] = ~gclk[g];
        if ($urandom_range(0, 99) < clk_tog) pt_clk = ~pt_clk;
        g_ce   = ($urandom_range(0, 99) < 80);
        pt_ce  = ($urandom_range(0, 99) < 80);
        g_rst  = ($urandom_range(0, 99) < ctl_rate);
        pt_rst = ($urandom_range(0, 99) < ctl_rate);
        g_set  = ($urandom_range(0, 99) < ctl_rate);
        pt_set = ($urandom_range(0, 99) < ctl_rate);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        sum_term = 0; bypass_term = 0; pad_in = 0; gclk = '0; pt_clk = 0;
        g_ce = 0; pt_ce = 0; g_rst = 0; pt_rst = 0; g_set = 0; pt_set = 0;
        cfg_use_bypass = 0; cfg_d_inv = 0; cfg_use_pad = 0; cfg_latch = 0;
        cfg_gclk_sel = 0; cfg_clk_pt = 0; cfg_ce_pt = 0; cfg_rst_pt = 0;
        cfg_set_pt = 0; cfg_comb_inv = 0;
        gclk = 4'b1111; pt_clk = 1;   // high into reset: tests cleared edge memory
        repeat (3) @(negedge clk);
        check_bit("R1 reset clears q", q_out, 0);
        rst_n = 1;
        // First cycle out of reset with clock already high is a rise (R1 history cleared).
        for (int ph = 0; ph < 32; ph++) begin
            cfg_latch      = ph[0];
            cfg_use_bypass = ph[1];
            cfg_d_inv      = ph[2];
            cfg_use_pad    = (ph % 7 == 3);
            cfg_clk_pt     = ph[3];
            cfg_gclk_sel   = 2'(ph >> 1);
            cfg_ce_pt      = ph[4];
            cfg_rst_pt     = ph[2] ^ ph[4];
            cfg_set_pt     = ph[1] ^ ph[3];
            cfg_comb_inv   = ph[0] ^ ph[2];
            if (ph == 17) rst_n = 0;
            for (int c = 0; c < 150; c++) begin
                @(negedge clk);
                check_bit(exp_tag, q_out, exp_q);
                check_bit("R10 comb output", comb_out,
                          int'(bypass_term ^ cfg_comb_inv));
                if (ph == 17 && c == 2) rst_n = 1;
                drive((ph % 3 == 0) ? 40 : 20, (ph % 4 == 1) ? 12 : 3);
                if (c > 140) begin g_rst = 0; pt_rst = 0; g_set = 0; pt_set = 0; end
            end
        end
        @(negedge clk);
        check_bit(exp_tag, q_out, exp_q);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule